// File: doc/BRIEF.md
# Parallel EEPROM Write-Protect Unlock Sequencer

This block sits in front of a byte-wide parallel EEPROM array and owns its software write-protection state. It watches the active-low chip-select, write and output strobes together with the 15-bit address and 8-bit data buses. A write is taken on the rising edge of the write strobe while chip-select is low. From reset the array is locked, and no byte write is allowed through to it.

To unlock, the host issues a fixed six-write pattern with no other access in between. When the last write of the pattern lands, a busy flag stays high for a programmable write-cycle time. When that time ends, protection drops and later chip-selected writes each raise a one-cycle write-permit pulse toward the array.

Chip-select is the device select. Output-enable and write-enable are shared by every device on the bus, so a strobe counts only while this device is selected. A deselected device sits in standby and never drives the data bus.

Top module: `wp_unlock_ctrl`

## Requirements
- R1: After reset `prot_o` is 1, and `busy_o` and `wr_permit_o` are 0.
- R2: The unlock pattern, all hex, is (address 5555, data AA), (2AAA, 55), (5555, 80), (5555, AA), (2AAA, 55), (5555, 20), taken in that order. `busy_o` is 1 in the cycle after the clock edge that takes the sixth write, and `prot_o` is still 1 in that cycle.
- R3: `busy_o` stays high for exactly `TWC_CYCLES` cycles. `prot_o` falls on the same edge as `busy_o`, and once cleared it stays 0 until reset.
- R4: While `prot_o` is 1, no write raises `wr_permit_o`. This includes the pattern writes themselves.
- R5: A selected write that does not match the expected step restarts matching. If that write is (5555, AA), it counts as step one, and the next write is compared with step two.
- R6: A read access (chip-select low and output-enable low) while a pattern is partly entered restarts matching at step one.
- R7: Strobes seen while chip-select is high neither advance nor break the pattern.
- R8: Once unprotected, each chip-selected write raises `wr_permit_o` for exactly one cycle, in the cycle after the edge that sees the write strobe rise.
- R9: `drive_en_o` is 1 only while chip-select and output-enable are both low.
- R10: `active_o` is 1 exactly while chip-select is low (active power mode). It is 0 in standby.
- R11: While `busy_o` is 1, writes are ignored: no permit pulse and no pattern matching.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ce_n | input | 1 | Chip select, active low |
| we_n | input | 1 | Write strobe, active low; a write is taken on its rising edge |
| oe_n | input | 1 | Output enable, active low |
| addr_i | input | 15 | Byte address |
| data_i | input | 8 | Write data |
| prot_o | output | 1 | Write protection active |
| busy_o | output | 1 | Write-cycle delay running |
| wr_permit_o | output | 1 | One-cycle pulse allowing a byte write into the array |
| drive_en_o | output | 1 | Permission to drive the data bus |
| active_o | output | 1 | Active power mode |

## Verification
The write strobe is registered once, so a write is recognised at the first clock edge after `we_n` goes high. The permit pulse and the rise of busy are both visible after that same edge. Busy then falls, and protection clears, `TWC_CYCLES` edges later. The bus-drive and power-mode outputs are combinational and follow the strobes in the same cycle. The bench drives inputs just after each rising edge and samples at the falling edge. A behavioural model, stepped at each rising edge, gives the expected state for the falling-edge comparison. Scenario checks sample at the exact falling edge where each of these results is due.

// File: rtl/wpu_pkg.sv
package wpu_pkg;
    localparam int ADDR_W  = 15;
    localparam int DATA_W  = 8;
    localparam int N_STEPS = 6;
    localparam int STEP_W  = $clog2(N_STEPS);

    typedef logic [STEP_W-1:0] step_idx_t;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } wr_beat_t;

    // Expected beat for each position of the unlock pattern
    function automatic wr_beat_t unlock_beat(input step_idx_t idx);
        wr_beat_t b;
        case (idx)
            step_idx_t'(0): b = '{addr: 15'h5555, data: 8'hAA};
            step_idx_t'(1): b = '{addr: 15'h2AAA, data: 8'h55};
            step_idx_t'(2): b = '{addr: 15'h5555, data: 8'h80};
            step_idx_t'(3): b = '{addr: 15'h5555, data: 8'hAA};
            step_idx_t'(4): b = '{addr: 15'h2AAA, data: 8'h55};
            default:        b = '{addr: 15'h5555, data: 8'h20};
        endcase
        return b;
    endfunction
endpackage

// File: rtl/wpu_strobe_detect.sv
module wpu_strobe_detect (
    input  logic clk,
    input  logic rst,
    input  logic ce_n,
    input  logic we_n,
    input  logic oe_n,
    output logic wr_evt,
    output logic rd_evt
);
    logic we_q;

    always_ff @(posedge clk) begin
        if (rst) we_q <= 1'b1;
        else     we_q <= we_n;
    end

    // Write is taken on the rising edge of the write strobe while selected
    assign wr_evt = !ce_n && !we_q && we_n;
    assign rd_evt = !ce_n && !oe_n;
endmodule

// File: rtl/wpu_seq_match.sv
module wpu_seq_match
    import wpu_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     en,
    input  logic     wr_evt,
    input  logic     rd_evt,
    input  wr_beat_t beat,
    output logic     seq_done
);
    localparam step_idx_t LAST = step_idx_t'(N_STEPS - 1);

    step_idx_t step_q;
    logic      hit, first_hit;

    assign hit       = (beat == unlock_beat(step_q));
    assign first_hit = (beat == unlock_beat(step_idx_t'(0)));
    assign seq_done  = en && !rd_evt && wr_evt && hit && (step_q == LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            step_q <= '0;
        end else if (en) begin
            if (rd_evt) begin
                step_q <= '0;
            end else if (wr_evt) begin
                if (hit)
                    step_q <= (step_q == LAST) ? '0 : step_q + step_idx_t'(1);
                else
                    step_q <= first_hit ? step_idx_t'(1) : '0;
            end
        end
    end
endmodule

// File: rtl/wpu_wc_timer.sv
module wpu_wc_timer #(
    parameter int TWC_CYCLES = 40
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic busy,
    output logic done
);
    localparam int CW = $clog2(TWC_CYCLES + 1);

    logic [CW-1:0] cnt_q;

    assign done = busy && (cnt_q == CW'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            busy  <= 1'b0;
        end else if (busy) begin
            cnt_q <= cnt_q - CW'(1);
            if (done) busy <= 1'b0;
        end else if (start) begin
            cnt_q <= CW'(TWC_CYCLES);
            busy  <= 1'b1;
        end
    end
endmodule

// File: rtl/wp_unlock_ctrl.sv
module wp_unlock_ctrl
    import wpu_pkg::*;
#(
    parameter int TWC_CYCLES = 40
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] data_i,
    output logic              prot_o,
    output logic              busy_o,
    output logic              wr_permit_o,
    output logic              drive_en_o,
    output logic              active_o
);
    logic     wr_evt, rd_evt, seq_done, wc_done;
    wr_beat_t beat;

    assign beat = '{addr: addr_i, data: data_i};

    wpu_strobe_detect u_strobe (
        .clk    (clk),
        .rst    (rst),
        .ce_n   (ce_n),
        .we_n   (we_n),
        .oe_n   (oe_n),
        .wr_evt (wr_evt),
        .rd_evt (rd_evt)
    );

    wpu_seq_match u_match (
        .clk      (clk),
        .rst      (rst),
        .en       (prot_o && !busy_o),
        .wr_evt   (wr_evt),
        .rd_evt   (rd_evt),
        .beat     (beat),
        .seq_done (seq_done)
    );

    wpu_wc_timer #(.TWC_CYCLES(TWC_CYCLES)) u_timer (
        .clk   (clk),
        .rst   (rst),
        .start (seq_done),
        .busy  (busy_o),
        .done  (wc_done)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            prot_o      <= 1'b1;
            wr_permit_o <= 1'b0;
        end else begin
            if (wc_done) prot_o <= 1'b0;
            wr_permit_o <= wr_evt && !prot_o && !busy_o;
        end
    end

    assign drive_en_o = !ce_n && !oe_n;
    assign active_o   = !ce_n;
endmodule

// File: rtl/wpu_checker.sv
module wpu_checker (
    input logic clk,
    input logic rst,
    input logic prot_o,
    input logic busy_o,
    input logic wr_permit_o
);
    // R4
    permit_unprot_chk: assert property (@(posedge clk) disable iff (rst)
        wr_permit_o |-> (!prot_o && !busy_o));

    // R8
    permit_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        wr_permit_o |=> !wr_permit_o);

    // R2
    busy_while_prot_chk: assert property (@(posedge clk) disable iff (rst)
        busy_o |-> prot_o);

    // R3
    unlock_after_busy_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(prot_o) |-> ($past(busy_o) && !busy_o));

    // R3
    stay_unlocked_chk: assert property (@(posedge clk) disable iff (rst)
        !prot_o |=> !prot_o);
endmodule

bind wp_unlock_ctrl wpu_checker u_chk (
    .clk         (clk),
    .rst         (rst),
    .prot_o      (prot_o),
    .busy_o      (busy_o),
    .wr_permit_o (wr_permit_o)
);

// File: tb/wp_unlock_ctrl_tb.sv
`timescale 1ns/1ps
module wp_unlock_ctrl_tb;
    localparam int TWC = 20;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
    logic [14:0] addr = '0;
    logic [7:0]  data = '0;
    logic        prot, busy, permit, drv, act;

    int n_tests = 0, n_fail = 0;
    logic last_permit;

    always #10 clk = ~clk;

    wp_unlock_ctrl #(.TWC_CYCLES(TWC)) u_dut (
        .clk(clk), .rst(rst), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
        .addr_i(addr), .data_i(data), .prot_o(prot), .busy_o(busy),
        .wr_permit_o(permit), .drive_en_o(drv), .active_o(act)
    );

    // Unlock pattern from R2
    logic [14:0] pa [6] = '{15'h5555, 15'h2AAA, 15'h5555, 15'h5555, 15'h2AAA, 15'h5555};
    logic [7:0]  pd [6] = '{8'hAA, 8'h55, 8'h80, 8'hAA, 8'h55, 8'h20};

    // Behavioural reference model
    int   m_step = 0, m_cnt = 0;
    logic m_prot = 1'b1, m_permit = 1'b0, m_weq = 1'b1;

    always @(posedge clk) begin
        logic ev, rd;
        if (rst) begin
            m_step = 0; m_cnt = 0; m_prot = 1'b1; m_permit = 1'b0; m_weq = 1'b1;
        end else begin
            ev = !ce_n && !m_weq && we_n;
            rd = !ce_n && !oe_n;
            m_permit = ev && !m_prot && (m_cnt == 0);
            if (m_cnt > 0) begin
                m_cnt = m_cnt - 1;
                if (m_cnt == 0) m_prot = 1'b0;
            end else if (m_prot) begin
                if (rd) m_step = 0;
                else if (ev) begin
                    if (addr == pa[m_step] && data == pd[m_step]) begin
                        if (m_step == 5) begin m_step = 0; m_cnt = TWC; end
                        else m_step = m_step + 1;
                    end else begin
                        m_step = (addr == 15'h5555 && data == 8'hAA) ? 1 : 0;
                    end
                end
            end
            m_weq = we_n;
        end
    end

    task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, got, exp);
        end
    endtask

    // Every-clock comparison against the model (R1 R2 R3 R4 R8 R9 R10 R11)
    always @(negedge clk) begin
        if (!rst) begin
            check("R3 model prot", {7'd0, prot}, {7'd0, m_prot});
            check("R2 model busy", {7'd0, busy}, {7'd0, m_cnt > 0});
            check("R8 model permit", {7'd0, permit}, {7'd0, m_permit});
            check("R9 drive", {7'd0, drv}, {7'd0, !ce_n && !oe_n});
            check("R10 active", {7'd0, act}, {7'd0, !ce_n});
        end
    end

    task automatic tick();
        @(posedge clk); #2;
    endtask

    task automatic do_write(input logic [14:0] a, input logic [7:0] d);
        tick(); ce_n = 1'b0; addr = a; data = d; we_n = 1'b0;
        tick(); we_n = 1'b1;
        tick(); ce_n = 1'b1;
        @(negedge clk); last_permit = permit;
    endtask

    task automatic do_read();
        tick(); ce_n = 1'b0; oe_n = 1'b0;
        @(negedge clk);
        check("R9 drive during read", {7'd0, drv}, 8'd1);
        check("R10 active during read", {7'd0, act}, 8'd1);
        tick(); ce_n = 1'b1; oe_n = 1'b1;
        @(negedge clk);
        check("R9 standby no drive", {7'd0, drv}, 8'd0);
        check("R10 standby", {7'd0, act}, 8'd0);
    endtask

    task automatic apply_reset();
        tick(); rst = 1'b1;
        repeat (3) tick();
        rst = 1'b0;
        @(negedge clk);
    endtask

    task automatic settle_locked(input string req);
        repeat (TWC + 5) tick();
        @(negedge clk);
        check(req, {6'd0, prot, busy}, 8'b10);
    endtask

    initial begin
        #(20 * 150000);
        n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        apply_reset();
        check("R1 reset prot", {7'd0, prot}, 8'd1);
        check("R1 reset busy", {7'd0, busy}, 8'd0);
        check("R1 reset permit", {7'd0, permit}, 8'd0);

        do_write(15'h0123, 8'h77);
        check("R4 stray write blocked", {7'd0, last_permit}, 8'd0);

        // R5: mismatch at step three breaks the pattern
        for (int i = 0; i < 6; i++) do_write(pa[i], (i == 2) ? 8'h81 : pd[i]);
        settle_locked("R5 mismatch keeps lock");

        // R6: read in the middle breaks the pattern
        for (int i = 0; i < 6; i++) begin
            if (i == 3) do_read();
            do_write(pa[i], pd[i]);
        end
        settle_locked("R6 read interrupt keeps lock");

        // R7: deselected strobe in the middle is ignored; pattern completes
        for (int i = 0; i < 6; i++) begin
            if (i == 2) begin
                tick(); addr = 15'h0001; data = 8'h00; we_n = 1'b0; oe_n = 1'b0;
                tick(); we_n = 1'b1; oe_n = 1'b1;
            end
            tick(); ce_n = 1'b0; addr = pa[i]; data = pd[i]; we_n = 1'b0;
            tick(); we_n = 1'b1;
            tick(); ce_n = 1'b1;
            @(negedge clk);
            check("R4 pattern write blocked", {7'd0, permit}, 8'd0);
        end
        check("R2 busy after sixth write", {7'd0, busy}, 8'd1);
        check("R2 still protected", {7'd0, prot}, 8'd1);
        check("R7 deselected strobe ignored", {7'd0, busy}, 8'd1);
        // sampled once already at this edge: TWC-1 more high samples
        for (int i = 1; i < TWC; i++) @(negedge clk);
        check("R3 busy held TWC cycles", {6'd0, prot, busy}, 8'b11);
        @(negedge clk);
        check("R3 unlock when busy ends", {6'd0, prot, busy}, 8'b00);

        do_write(15'h0042, 8'h99);
        check("R8 permit pulse", {7'd0, last_permit}, 8'd1);
        @(negedge clk);
        check("R8 permit one cycle", {7'd0, permit}, 8'd0);

        // R5: repeated first step counts as step one
        apply_reset();
        do_write(15'h5555, 8'hAA);
        for (int i = 0; i < 6; i++) do_write(pa[i], pd[i]);
        check("R5 restart at step two", {7'd0, busy}, 8'd1);
        do_write(15'h0010, 8'h11);
        check("R11 write during busy blocked", {7'd0, last_permit}, 8'd0);
        repeat (TWC) tick();
        @(negedge clk);
        check("R11 unlock unaffected", {6'd0, prot, busy}, 8'b00);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule